// File: doc/BRIEF.md
# Byte-Wide SPI Port Controller

This block is a serial peripheral port that exchanges one byte at a time with a remote device, as either the clock-driving master or a selected slave. A processor reaches it through a two-location register window: the data location and the status location. Writing the data location while idle loads the shift register and, in master mode, starts eight serial clock periods. Reading the data location returns the last completed byte from a separate receive buffer. Configuration (mode, rate, interrupt enable) arrives on plain control inputs.

The master serial clock is the system clock divided by 4, 16, 64 or 128. The status location holds a transfer-complete flag and a write-collision flag. A hardware acknowledge strobe clears the completion flag. So does a two-step sequence: a status read that sees the flag set, followed by any data access. A select line that is pulled low while the port is a master with its select pin set as an input aborts the transfer and raises the completion flag, so software can see the bus conflict.

Top module: `spi_port`

## Requirements
- R1: Rate code ctlRate = 0, 1, 2, 3 gives a master SCK period of 4, 16, 64, 128 system clocks. The completion flag rises exactly 8 SCK periods after the clock edge that accepts the data write.
- R2: In master mode the byte is exchanged full duplex, MSB first. SCK idles low, MOSI changes after the falling SCK edge, MISO is sampled at the rising edge, and SCK is high only during a transfer.
- R3: irq is high exactly when the completion flag, ctlIrqEn and globalIrqEn are all high.
- R4: A data read (addrData = 1) returns the receive buffer. The buffer changes only in the cycle that sets the completion flag and holds its value while a later transfer is in progress.
- R5: A data write while a transfer is in progress sets the collision flag and is otherwise ignored: the ongoing byte is sent unchanged.
- R6: A status read that sees the completion flag set, followed by a data read or data write, clears the flag. A status read that sees the flag clear disarms this sequence.
- R7: The status location (addrData = 0) reads the completion flag in bit 7, the collision flag in bit 6 and zero in bits 5..0. Both flags are zero after reset.
- R8: An intAck pulse clears the completion flag.
- R9: A status read that sees the collision flag set, followed by a data access, clears both flags.
- R10: In master mode with selDirIn = 1, a falling edge on ssIn sets the completion flag, aborts the transfer and returns SCK low. With selDirIn = 0 the select line has no effect.
- R11: In slave mode (ctlMaster = 0) the port shifts while ssIn is low: it samples mosiIn on rising sckIn and drives misoOut MSB first. sckOut stays low whatever ctlRate holds. A byte loaded while deselected is sent, and the received byte lands in the buffer with the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlMaster | input | 1 | 1 = master, 0 = slave |
| ctlRate | input | 2 | Master SCK rate code |
| ctlIrqEn | input | 1 | Completion interrupt enable |
| globalIrqEn | input | 1 | Global interrupt enable |
| selDirIn | input | 1 | Select pin configured as input (master fault detection) |
| addrData | input | 1 | Register select: 1 = data, 0 = status |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected location |
| intAck | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Interrupt request |
| sckOut | output | 1 | Master serial clock |
| mosiOut | output | 1 | Master serial data out |
| misoIn | input | 1 | Master serial data in |
| sckIn | input | 1 | Slave serial clock in |
| mosiIn | input | 1 | Slave serial data in |
| ssIn | input | 1 | Active-low select input |
| misoOut | output | 1 | Slave serial data out |

## Verification
The assertions assume that the register strobes are single-cycle pulses and that ctlMaster does not change while a byte is moving. Only then does a high sckOut always mean a live transfer, and only then is every fall of a flag traceable to an acknowledge or a data access. The stimulus changes mode and rate only between transfers, with the flags cleared, and pulses each strobe for one cycle at a falling clock edge. Slave-mode serial inputs are held for several system clocks per level, well above the three-stage synchronizer delay.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  // Per-cycle commands from the sequencer to the shift datapath
  typedef struct packed {
    logic load;     // parallel load of the shift register from the bus
    logic sample;   // latch the incoming serial bit
    logic shift;    // shift left, inserting the latched bit
    logic capture;  // copy the completed byte into the receive buffer
    logic inBit;    // incoming serial bit for the active mode
  } dpStrobe_t;
endpackage

// File: rtl/spi_port_ctrl.sv
`timescale 1ns/1ps
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV0   = 4,
  parameter int DIV1   = 16,
  parameter int DIV2   = 64,
  parameter int DIV3   = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlMaster,
  input  logic [1:0] ctlRate,
  input  logic       ctlIrqEn,
  input  logic       globalIrqEn,
  input  logic       selDirIn,
  input  logic       addrData,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic       intAck,
  input  logic       misoIn,
  input  logic       sckIn,
  input  logic       mosiIn,
  input  logic       ssIn,
  output dpStrobe_t  strobe,
  output logic       sckOut,
  output logic       busy,
  output logic       slaveSel,
  output logic       spifFlag,
  output logic       wcolFlag,
  output logic       irq
);
  localparam int HALF_W = $clog2(DIV3 / 2) + 1;
  localparam int BIT_W  = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  // Slave-side synchronizers: [0],[1] sync, [2] previous for edge detect
  logic [2:0] sckSh, mosiSh, ssSh;
  logic       sckRise, sckFall, ssLow, ssFallEdge, mosiS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh  <= '0;
      mosiSh <= '0;
      ssSh   <= '1;
    end else begin
      sckSh  <= {sckSh[1:0], sckIn};
      mosiSh <= {mosiSh[1:0], mosiIn};
      ssSh   <= {ssSh[1:0], ssIn};
    end
  end

  assign sckRise    = sckSh[1] & ~sckSh[2];
  assign sckFall    = ~sckSh[1] & sckSh[2];
  assign ssLow      = ~ssSh[1];
  assign ssFallEdge = ~ssSh[1] & ssSh[2];
  assign mosiS      = mosiSh[1];

  // Half-period length in system clocks for the selected rate
  logic [HALF_W-1:0] halfLim;
  always_comb begin
    unique case (ctlRate)
      2'd0:    halfLim = HALF_W'(DIV0 / 2);
      2'd1:    halfLim = HALF_W'(DIV1 / 2);
      2'd2:    halfLim = HALF_W'(DIV2 / 2);
      default: halfLim = HALF_W'(DIV3 / 2);
    endcase
  end

  logic              mBusy, sckReg;
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              halfEnd, lastBit;
  logic              dataWr, dataRd, statRd, dataAcc;
  logic              collide, modeFault;

  assign dataWr    = wrEn & addrData;
  assign dataRd    = rdEn & addrData;
  assign statRd    = rdEn & ~addrData;
  assign dataAcc   = dataWr | dataRd;
  assign slaveSel  = ~ctlMaster & ssLow;
  assign busy      = mBusy | slaveSel;
  assign collide   = dataWr & busy;
  assign modeFault = ctlMaster & selDirIn & ssFallEdge;
  assign halfEnd   = mBusy & (halfCnt == halfLim - HALF_W'(1));
  assign lastBit   = (bitCnt == BIT_W'(DATA_W - 1));

  always_comb begin
    strobe        = '0;
    strobe.inBit  = ctlMaster ? misoIn : mosiS;
    strobe.load   = dataWr & ~busy;
    if (ctlMaster) begin
      strobe.sample = halfEnd & ~sckReg & ~modeFault;
      strobe.shift  = halfEnd & sckReg & ~modeFault;
    end else begin
      strobe.sample = ssLow & sckRise;
      strobe.shift  = ssLow & sckFall;
    end
    strobe.capture = strobe.shift & lastBit;
  end

  // Transfer sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy   <= 1'b0;
      sckReg  <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else if (modeFault) begin
      mBusy   <= 1'b0;
      sckReg  <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else if (ctlMaster) begin
      if (strobe.load) begin
        mBusy   <= 1'b1;
        sckReg  <= 1'b0;
        halfCnt <= '0;
        bitCnt  <= '0;
      end else if (mBusy) begin
        if (halfEnd) begin
          halfCnt <= '0;
          sckReg  <= ~sckReg;
          if (sckReg) begin
            bitCnt <= lastBit ? '0 : bitCnt + BIT_W'(1);
            if (lastBit) mBusy <= 1'b0;
          end
        end else begin
          halfCnt <= halfCnt + HALF_W'(1);
        end
      end
    end else begin
      mBusy  <= 1'b0;
      sckReg <= 1'b0;
      if (!ssLow)           bitCnt <= '0;
      else if (strobe.shift) bitCnt <= lastBit ? '0 : bitCnt + BIT_W'(1);
    end
  end

  assign sckOut = sckReg;

  // Status flags and the two-step clear sequence
  logic spifArm, wcolArm, setSpif, clrSpif, clrWcol;
  assign setSpif = strobe.capture | modeFault;
  assign clrSpif = intAck | (dataAcc & (spifArm | wcolArm));
  assign clrWcol = dataAcc & wcolArm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spifArm  <= 1'b0;
      wcolArm  <= 1'b0;
      spifFlag <= 1'b0;
      wcolFlag <= 1'b0;
    end else begin
      if (statRd) begin
        spifArm <= spifFlag;
        wcolArm <= wcolFlag;
      end else if (dataAcc) begin
        spifArm <= 1'b0;
        wcolArm <= 1'b0;
      end
      if (setSpif)      spifFlag <= 1'b1;
      else if (clrSpif) spifFlag <= 1'b0;
      if (collide)      wcolFlag <= 1'b1;
      else if (clrWcol) wcolFlag <= 1'b0;
    end
  end

  assign irq = spifFlag & ctlIrqEn & globalIrqEn;
endmodule

// File: rtl/spi_port_dp.sv
`timescale 1ns/1ps
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              addrData,
  input  logic              spifFlag,
  input  logic              wcolFlag,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rxBuf,
  output logic              txBit
);
  logic [DATA_W-1:0] shiftReg;
  logic              sampleBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      sampleBit <= 1'b0;
      rxBuf     <= '0;
    end else begin
      if (strobe.load)       shiftReg <= wrData;
      else if (strobe.shift) shiftReg <= {shiftReg[DATA_W-2:0], sampleBit};
      if (strobe.sample)     sampleBit <= strobe.inBit;
      if (strobe.capture)    rxBuf <= {shiftReg[DATA_W-2:0], sampleBit};
    end
  end

  assign txBit  = shiftReg[DATA_W-1];
  assign rdData = addrData ? rxBuf : {spifFlag, wcolFlag, {(DATA_W-2){1'b0}}};
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV0   = 4,
  parameter int DIV1   = 16,
  parameter int DIV2   = 64,
  parameter int DIV3   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlMaster,
  input  logic [1:0]        ctlRate,
  input  logic              ctlIrqEn,
  input  logic              globalIrqEn,
  input  logic              selDirIn,
  input  logic              addrData,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              intAck,
  output logic              irq,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              ssIn,
  output logic              misoOut
);
  dpStrobe_t         strobe;
  logic              busy, slaveSel, spifFlag, wcolFlag, txBit;
  logic [DATA_W-1:0] rxBuf;

  spi_port_ctrl #(
    .DATA_W(DATA_W), .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlMaster(ctlMaster), .ctlRate(ctlRate),
    .ctlIrqEn(ctlIrqEn), .globalIrqEn(globalIrqEn), .selDirIn(selDirIn),
    .addrData(addrData), .rdEn(rdEn), .wrEn(wrEn), .intAck(intAck),
    .misoIn(misoIn), .sckIn(sckIn), .mosiIn(mosiIn), .ssIn(ssIn),
    .strobe(strobe), .sckOut(sckOut), .busy(busy), .slaveSel(slaveSel),
    .spifFlag(spifFlag), .wcolFlag(wcolFlag), .irq(irq)
  );

  spi_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .addrData(addrData), .spifFlag(spifFlag), .wcolFlag(wcolFlag),
    .rdData(rdData), .rxBuf(rxBuf), .txBit(txBit)
  );

  assign mosiOut = ctlMaster & txBit;
  assign misoOut = slaveSel & txBit;
endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              wrEn,
  input logic              addrData,
  input logic              intAck,
  input logic              ctlIrqEn,
  input logic              globalIrqEn,
  input logic              irq,
  input logic              sckOut,
  input logic              busy,
  input logic              spifFlag,
  input logic              wcolFlag,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] rxBuf
);
  a_r2_sck_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    sckOut |-> busy);

  a_r3_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctlIrqEn && globalIrqEn && spifFlag));

  a_r4_rx_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxBuf) |-> spifFlag);

  a_r5_wcol_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wcolFlag) |-> $past(wrEn && addrData));

  a_r6_spif_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spifFlag) |-> $past(intAck || ((rdEn || wrEn) && addrData)));

  a_r9_wcol_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wcolFlag) |-> $past((rdEn || wrEn) && addrData));

  a_r7_status_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    !addrData |-> (rdData[DATA_W-3:0] == '0));
endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addrData(addrData),
  .intAck(intAck), .ctlIrqEn(ctlIrqEn), .globalIrqEn(globalIrqEn),
  .irq(irq), .sckOut(sckOut), .busy(busy), .spifFlag(spifFlag),
  .wcolFlag(wcolFlag), .rdData(rdData), .rxBuf(rxBuf)
);

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlMaster = 1'b1, ctlIrqEn = 1'b0, globalIrqEn = 1'b0, selDirIn = 1'b0;
  logic [1:0] ctlRate = 2'd0;
  logic       addrData = 1'b1, rdEn = 1'b0, wrEn = 1'b0, intAck = 1'b0;
  logic [7:0] wrData = 8'h00, rdData;
  logic       irq, sckOut, mosiOut, misoIn, misoOut;
  logic       sckIn = 1'b0, mosiIn = 1'b0, ssIn = 1'b1;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_port u_dut (
    .clk(clk), .rstN(rstN), .ctlMaster(ctlMaster), .ctlRate(ctlRate),
    .ctlIrqEn(ctlIrqEn), .globalIrqEn(globalIrqEn), .selDirIn(selDirIn),
    .addrData(addrData), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .intAck(intAck), .irq(irq), .sckOut(sckOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .sckIn(sckIn), .mosiIn(mosiIn),
    .ssIn(ssIn), .misoOut(misoOut)
  );

  // Remote slave model for master-mode transfers
  logic [7:0] remTx = 8'h00, remRx = 8'h00;
  assign misoIn = remTx[7];
  always @(posedge sckOut) remRx <= {remRx[6:0], mosiOut};
  always @(negedge sckOut) remTx <= {remTx[6:0], 1'b0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic a, input logic [7:0] d);
    @(negedge clk); addrData = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; addrData = 1'b1;
  endtask

  task automatic regRead(input logic a, output logic [7:0] v);
    @(negedge clk); addrData = a; rdEn = 1'b1; #1 v = rdData;
    @(negedge clk); rdEn = 1'b0; addrData = 1'b1;
  endtask

  task automatic peekStat(output logic [7:0] s);
    addrData = 1'b0; #1 s = rdData; addrData = 1'b1; #1;
  endtask

  task automatic pulseAck();
    @(negedge clk); intAck = 1'b1; @(negedge clk); intAck = 1'b0;
  endtask

  // Start a master transfer, return system clocks until the completion flag
  task automatic xfer(input logic [7:0] tx, input logic [7:0] rem, output int n);
    logic [7:0] s;
    remTx = rem;
    regWrite(1'b1, tx);
    n = 0;
    peekStat(s);
    while (!s[7] && n < 5000) begin
      @(negedge clk); n++; peekStat(s);
    end
  endtask

  task automatic clearSeq();
    logic [7:0] v;
    regRead(1'b0, v);
    regRead(1'b1, v);
  endtask

  // Scoreboard
  logic [7:0] expRx[$], expTx[$];
  bit monOn = 0;
  logic irqPrev = 1'b0;
  always @(negedge clk) begin
    irqPrev <= irq;
    if (monOn && irq && !irqPrev) begin
      if (expRx.size() == 0) chk("R2 scoreboard underrun", 1, 0);
      else begin
        chk("R2 scoreboard received byte", {24'h0, rdData}, {24'h0, expRx.pop_front()});
        chk("R2 scoreboard remote captured", {24'h0, remRx}, {24'h0, expTx.pop_front()});
      end
    end
  end

  function automatic int divOf(input int r);
    case (r) 0: return 4; 1: return 16; 2: return 64; default: return 128; endcase
  endfunction

  initial begin
    #1520000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, v, got;
    int n;
    tick(3);
    rstN = 1'b1;
    tick(2);

    // R7 reset state
    peekStat(s);
    chk("R7 status after reset", {24'h0, s}, 32'h0);
    chk("R3 irq after reset", {31'h0, irq}, 32'h0);
    chk("R2 sck idle after reset", {31'h0, sckOut}, 32'h0);

    // R1, R2, R4, R6, R7 across all rates
    for (int r = 0; r < 4; r++) begin
      logic [7:0] tx, rem;
      tx = 8'(8'hA1 + r * 8'h17);
      rem = 8'(8'h3C ^ (r * 8'h29));
      ctlRate = 2'(r);
      xfer(tx, rem, n);
      chk("R1 transfer length", n, 8 * divOf(r));
      chk("R2 remote received MSB first", {24'h0, remRx}, {24'h0, tx});
      regRead(1'b0, s);
      chk("R7 status with flag set", {24'h0, s}, 32'h80);
      regRead(1'b1, v);
      chk("R4 data read returns received byte", {24'h0, v}, {24'h0, rem});
      peekStat(s);
      chk("R6 status read then data read clears", {24'h0, s}, 32'h0);
    end

    // R3 / R8 interrupt gating and acknowledge
    ctlRate = 2'd0;
    ctlIrqEn = 1'b1; globalIrqEn = 1'b0;
    xfer(8'h55, 8'hC3, n);
    tick(1);
    chk("R3 irq blocked by global enable", {31'h0, irq}, 32'h0);
    globalIrqEn = 1'b1; #1;
    chk("R3 irq with both enables", {31'h0, irq}, 32'h1);
    pulseAck();
    peekStat(s);
    chk("R8 intAck clears flag", {24'h0, s}, 32'h0);
    chk("R3 irq drops after clear", {31'h0, irq}, 32'h0);
    globalIrqEn = 1'b0;

    // R4 buffer not live during a transfer
    ctlRate = 2'd1;
    remTx = 8'h0F;
    regWrite(1'b1, 8'hF0);
    tick(70);
    #1 chk("R4 buffer held mid-transfer", {24'h0, rdData}, 32'hC3);
    tick(80);
    pulseAck();

    // R5 collision, R9 collision clear
    xfer(8'hA5, 8'h5A, n); pulseAck();
    remTx = 8'h66;
    regWrite(1'b1, 8'hA5);
    tick(20);
    regWrite(1'b1, 8'hFF);
    peekStat(s);
    chk("R5 collision flag set", {24'h0, s}, 32'h40);
    tick(140);
    chk("R5 colliding write ignored", {24'h0, remRx}, 32'hA5);
    peekStat(s);
    chk("R5 both flags after transfer", {24'h0, s}, 32'hC0);
    regRead(1'b0, s);
    regRead(1'b1, v);
    chk("R4 data after collision", {24'h0, v}, 32'h66);
    peekStat(s);
    chk("R9 sequence clears both flags", {24'h0, s}, 32'h0);

    // R6 disarm by a status read with the flag clear
    ctlRate = 2'd0;
    xfer(8'h12, 8'h34, n);
    regRead(1'b0, s);
    pulseAck();
    regRead(1'b0, s);
    xfer(8'h56, 8'h78, n);
    regRead(1'b1, v);
    peekStat(s);
    chk("R6 disarmed sequence leaves flag", {24'h0, s}, 32'h80);
    // R6 clear by a data write that also starts the next byte
    regRead(1'b0, s);
    regWrite(1'b1, 8'h9A);
    peekStat(s);
    chk("R6 status read then data write clears", {24'h0, s}, 32'h0);
    tick(40);
    pulseAck();

    // R10 mode fault
    ctlRate = 2'd3;
    selDirIn = 1'b1;
    regWrite(1'b1, 8'hE7);
    tick(200);
    ssIn = 1'b0;
    tick(6);
    peekStat(s);
    chk("R10 fault sets flag", {24'h0, s}, 32'h80);
    tick(150);
    chk("R10 fault leaves sck low", {31'h0, sckOut}, 32'h0);
    ssIn = 1'b1; tick(4);
    pulseAck();
    selDirIn = 1'b0;
    ssIn = 1'b0; tick(6);
    peekStat(s);
    chk("R10 select ignored as output", {24'h0, s}, 32'h0);
    ssIn = 1'b1; tick(4);

    // R11 slave mode
    ctlMaster = 1'b0;
    ctlRate = 2'd0;
    regWrite(1'b1, 8'h96);
    ssIn = 1'b0;
    tick(4);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      mosiIn = (8'h4B >> i) & 1;
      tick(6);
      got = {got[6:0], misoOut};
      chk("R11 sckOut idle in slave mode", {31'h0, sckOut}, 32'h0);
      sckIn = 1'b1; tick(6);
      sckIn = 1'b0; tick(6);
    end
    tick(2);
    chk("R11 misoOut sends loaded byte", {24'h0, got}, 32'h96);
    peekStat(s);
    chk("R11 slave completion flag", {24'h0, s}, 32'h80);
    #1 chk("R11 slave received byte", {24'h0, rdData}, 32'h4B);
    ssIn = 1'b1; tick(4);
    pulseAck();
    ctlMaster = 1'b1;

    // Scoreboard run, R2/R3 with irq as completion event
    globalIrqEn = 1'b1; ctlIrqEn = 1'b1;
    monOn = 1;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] tx, rem;
      tx  = 8'(k * 37 + 5);
      rem = 8'({tx[3:0], tx[7:4]} ^ 8'h5A);
      ctlRate = 2'(k % 3);
      expRx.push_back(rem);
      expTx.push_back(tx);
      remTx = rem;
      regWrite(1'b1, tx);
      n = 0;
      while (!irq && n < 3000) begin @(negedge clk); n++; end
      tick(1);
      pulseAck();
    end
    tick(2);
    monOn = 0;
    chk("R2 scoreboard drained", expRx.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule